// File: doc/BRIEF.md
# Thread Context Ring Matcher

This block decides whether an incoming notification targets a software entity that is currently dispatched on one hardware thread, and if so at which privilege ring. The thread holds four context rings: physical, pool, OS and user. Each has a valid flag, and the pool and OS rings also hold a stored 28-bit identity. The user ring instead holds a logical server number. A request carries a format bit, an ignore bit, a target block and index, and a logical server number. The block answers one clock after the request with a 3-bit ring code.

The physical ring has no stored identity. It is compared against an identity line that the block builds itself from the chip block id, the processor id and a configuration bit. That bit selects a 7-bit or an 8-bit thread id. The same line is also driven out combinationally so that neighbouring logic can use it.

The logic that evaluates pending priorities after a match sits downstream of this block.

Top module: `ctxm_ring_match`

## Requirements
- R1: A request sampled with `req_valid_i` high produces `hit_vld_o` high on the next clock edge. Without a request, `hit_vld_o` is low and `hit_ring_o` is 0.
- R2: The ring code on `hit_ring_o` uses these values: 0 = none, 1 = user, 2 = OS, 3 = pool, 4 = physical.
- R3: When the format bit is 0 and the ignore bit is 1, the result is 0 (none) whatever the context holds.
- R4: When the format bit is 0, the physical ring matches if its valid flag is set and the target identity equals the hardware identity line. This match wins over every other ring.
- R5: When the format bit is 0 and the physical ring does not match, the pool ring matches if its valid flag is set and its stored identity equals the target.
- R6: When the format bit is 0 and neither the physical nor the pool ring matches, the OS ring matches if its valid flag is set and its stored identity equals the target. Otherwise the result is 0.
- R7: When the format bit is 1, only the user ring can match. It needs all four of these:
  - the OS valid flag is set;
  - the stored OS identity equals the target;
  - the user valid flag is set;
  - the stored logical server number equals the request's.

  With format 1, the ignore bit and the physical and pool rings have no effect.
- R8: The hardware identity line `hw_cam_o` is {chip block id in bits 27:24, index in bits 23:0}. The index is 0x100 | pid[7:0] when `tid_wide_i` is 1, and 0x80 | pid[6:0] when it is 0.
- R9: While `rst_ni` is low, `hit_vld_o` and `hit_ring_o` are 0.
- R10: The target identity is {block in bits 27:24, index in bits 23:0}, and every comparison uses all 28 bits. A target that differs only in its block does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_fmt_i | input | 1 | 0 = specific target, 1 = user-level target |
| req_ign_i | input | 1 | Ignore low identity bits (unsupported, format 0 only) |
| req_blk_i | input | 4 | Target block |
| req_idx_i | input | 24 | Target index |
| req_lsn_i | input | 8 | Requested logical server number |
| chip_blk_i | input | 4 | Block id of this chip |
| pid_i | input | 16 | Processor id of the thread |
| tid_wide_i | input | 1 | 1 = 8-bit thread id, 0 = 7-bit |
| phys_vld_i | input | 1 | Physical ring valid |
| pool_vld_i | input | 1 | Pool ring valid |
| pool_cam_i | input | 28 | Pool ring stored identity |
| os_vld_i | input | 1 | OS ring valid |
| os_cam_i | input | 28 | OS ring stored identity |
| usr_vld_i | input | 1 | User ring valid |
| usr_lsn_i | input | 8 | User ring logical server number |
| hw_cam_o | output | 28 | Hardware identity line (combinational) |
| hit_vld_o | output | 1 | Result valid |
| hit_ring_o | output | 3 | Matched ring code |

## Verification
The physical, pool and OS comparisons are evaluated in the same cycle, so one request can satisfy several rings at once. The bench provokes this by loading the hardware identity, the pool identity and the OS identity with the same value and sending a request for that target. The result must be the physical code. With the physical flag cleared, the same target must give the pool code. A second overlap concerns the thread-id width bit, which changes the identity line that the physical comparison uses. The bench toggles this bit while keeping the same target and checks that the match appears or disappears as R8 predicts.

// File: rtl/ctxm_pkg.sv
package ctxm_pkg;
  localparam int unsigned BLK_W = 4;
  localparam int unsigned IDX_W = 24;
  localparam int unsigned CAM_W = BLK_W + IDX_W;

  typedef enum logic [2:0] {
    RING_NONE = 3'd0,
    RING_USER = 3'd1,
    RING_OS   = 3'd2,
    RING_POOL = 3'd3,
    RING_PHYS = 3'd4
  } ring_e;
endpackage

// File: rtl/ctxm_hw_cam.sv
module ctxm_hw_cam #(
  parameter int unsigned BLK_W      = 4,
  parameter int unsigned IDX_W      = 24,
  parameter int unsigned PID_W      = 16,
  parameter int unsigned TID_NARROW = 7,
  parameter int unsigned TID_WIDE   = 8
) (
  input  logic [BLK_W-1:0]       chip_blk_i,
  input  logic [PID_W-1:0]       pid_i,
  input  logic                   tid_wide_i,
  output logic [BLK_W+IDX_W-1:0] cam_o
);
  localparam logic [IDX_W-1:0] ONE    = IDX_W'(1);
  localparam logic [IDX_W-1:0] MARK_N = ONE << TID_NARROW;
  localparam logic [IDX_W-1:0] MARK_W = ONE << TID_WIDE;
  localparam logic [IDX_W-1:0] MASK_N = MARK_N - ONE;
  localparam logic [IDX_W-1:0] MASK_W = MARK_W - ONE;

  logic [IDX_W-1:0] pid_ext;
  logic [IDX_W-1:0] tid_val;

  assign pid_ext = IDX_W'(pid_i);

  // marker bit sits just above the thread id field
  always_comb begin
    if (tid_wide_i) tid_val = MARK_W | (pid_ext & MASK_W);
    else            tid_val = MARK_N | (pid_ext & MASK_N);
  end

  assign cam_o = {chip_blk_i, tid_val};
endmodule

// File: rtl/ctxm_cam_cmp.sv
module ctxm_cam_cmp #(
  parameter int unsigned CAM_W = 28
) (
  input  logic             vld_i,
  input  logic [CAM_W-1:0] stored_i,
  input  logic [CAM_W-1:0] target_i,
  output logic             hit_o
);
  assign hit_o = vld_i && (stored_i == target_i);
endmodule

// File: rtl/ctxm_ring_sel.sv
module ctxm_ring_sel
  import ctxm_pkg::*;
(
  input  logic  fmt_i,
  input  logic  ign_i,
  input  logic  phys_hit_i,
  input  logic  pool_hit_i,
  input  logic  os_hit_i,
  input  logic  usr_ok_i,
  output ring_e ring_o
);
  always_comb begin
    ring_o = RING_NONE;
    if (fmt_i) begin
      if (os_hit_i && usr_ok_i) ring_o = RING_USER;
    end else if (!ign_i) begin
      if (phys_hit_i)      ring_o = RING_PHYS;
      else if (pool_hit_i) ring_o = RING_POOL;
      else if (os_hit_i)   ring_o = RING_OS;
    end
  end
endmodule

// File: rtl/ctxm_ring_match.sv
module ctxm_ring_match
  import ctxm_pkg::*;
#(
  parameter int unsigned LSN_W = 8,
  parameter int unsigned PID_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_fmt_i,
  input  logic             req_ign_i,
  input  logic [BLK_W-1:0] req_blk_i,
  input  logic [IDX_W-1:0] req_idx_i,
  input  logic [LSN_W-1:0] req_lsn_i,
  input  logic [BLK_W-1:0] chip_blk_i,
  input  logic [PID_W-1:0] pid_i,
  input  logic             tid_wide_i,
  input  logic             phys_vld_i,
  input  logic             pool_vld_i,
  input  logic [CAM_W-1:0] pool_cam_i,
  input  logic             os_vld_i,
  input  logic [CAM_W-1:0] os_cam_i,
  input  logic             usr_vld_i,
  input  logic [LSN_W-1:0] usr_lsn_i,
  output logic [CAM_W-1:0] hw_cam_o,
  output logic             hit_vld_o,
  output logic [2:0]       hit_ring_o
);
  localparam int unsigned N_CMP = 3; // 0 phys, 1 pool, 2 os

  logic [CAM_W-1:0] target;
  logic [CAM_W-1:0] hw_cam;
  logic [CAM_W-1:0] stored [N_CMP];
  logic [N_CMP-1:0] vld;
  logic [N_CMP-1:0] hit;
  logic             usr_ok;
  ring_e            ring_n;

  assign target = {req_blk_i, req_idx_i};

  ctxm_hw_cam #(
    .BLK_W(BLK_W), .IDX_W(IDX_W), .PID_W(PID_W),
    .TID_NARROW(7), .TID_WIDE(8)
  ) u_hw_cam (
    .chip_blk_i (chip_blk_i),
    .pid_i      (pid_i),
    .tid_wide_i (tid_wide_i),
    .cam_o      (hw_cam)
  );

  assign stored[0] = hw_cam;
  assign stored[1] = pool_cam_i;
  assign stored[2] = os_cam_i;
  assign vld       = {os_vld_i, pool_vld_i, phys_vld_i};

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    ctxm_cam_cmp #(.CAM_W(CAM_W)) u_cmp (
      .vld_i    (vld[g]),
      .stored_i (stored[g]),
      .target_i (target),
      .hit_o    (hit[g])
    );
  end

  assign usr_ok = usr_vld_i && (usr_lsn_i == req_lsn_i);

  ctxm_ring_sel u_sel (
    .fmt_i      (req_fmt_i),
    .ign_i      (req_ign_i),
    .phys_hit_i (hit[0]),
    .pool_hit_i (hit[1]),
    .os_hit_i   (hit[2]),
    .usr_ok_i   (usr_ok),
    .ring_o     (ring_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_vld_o  <= 1'b0;
      hit_ring_o <= RING_NONE;
    end else begin
      hit_vld_o  <= req_valid_i;
      hit_ring_o <= req_valid_i ? ring_n : RING_NONE;
    end
  end

  assign hw_cam_o = hw_cam;
endmodule

// File: rtl/ctxm_ring_match_chk.sv
module ctxm_ring_match_chk
  import ctxm_pkg::*;
#(
  parameter int unsigned LSN_W = 8,
  parameter int unsigned PID_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_fmt_i,
  input logic             req_ign_i,
  input logic [BLK_W-1:0] chip_blk_i,
  input logic             tid_wide_i,
  input logic             phys_vld_i,
  input logic             pool_vld_i,
  input logic             os_vld_i,
  input logic             usr_vld_i,
  input logic [CAM_W-1:0] hw_cam_o,
  input logic             hit_vld_o,
  input logic [2:0]       hit_ring_o
);
  p_vld_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> hit_vld_o);
  p_idle_none_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_vld_o |-> hit_ring_o == RING_NONE);
  p_code_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_ring_o <= RING_PHYS);
  p_ign_none_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_fmt_i && req_ign_i |=> hit_ring_o == RING_NONE);
  p_no_valid_none_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_fmt_i && !phys_vld_i && !pool_vld_i && !os_vld_i
    |=> hit_ring_o == RING_NONE);
  p_fmt1_user_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_fmt_i |=> hit_ring_o inside {RING_NONE, RING_USER});
  p_fmt1_needs_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_fmt_i && !(os_vld_i && usr_vld_i) |=> hit_ring_o == RING_NONE);
  p_fmt0_no_user_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_fmt_i |=> hit_ring_o != RING_USER);
  p_cam_wide_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tid_wide_i |-> hw_cam_o[8] && hw_cam_o[IDX_W-1:9] == '0);
  p_cam_narrow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tid_wide_i |-> hw_cam_o[7] && hw_cam_o[IDX_W-1:8] == '0);
  p_cam_blk_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_cam_o[CAM_W-1:IDX_W] == chip_blk_i);
endmodule

bind ctxm_ring_match ctxm_ring_match_chk #(.LSN_W(LSN_W), .PID_W(PID_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_fmt_i   (req_fmt_i),
  .req_ign_i   (req_ign_i),
  .chip_blk_i  (chip_blk_i),
  .tid_wide_i  (tid_wide_i),
  .phys_vld_i  (phys_vld_i),
  .pool_vld_i  (pool_vld_i),
  .os_vld_i    (os_vld_i),
  .usr_vld_i   (usr_vld_i),
  .hw_cam_o    (hw_cam_o),
  .hit_vld_o   (hit_vld_o),
  .hit_ring_o  (hit_ring_o)
);

// File: tb/sim_ctxm_ring_match.sv
module sim_ctxm_ring_match;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_fmt_i = 1'b0, req_ign_i = 1'b0;
  logic [3:0]  req_blk_i = '0;
  logic [23:0] req_idx_i = '0;
  logic [7:0]  req_lsn_i = '0;
  logic [3:0]  chip_blk_i = 4'h3;
  logic [15:0] pid_i = 16'h01A5;
  logic        tid_wide_i = 1'b0;
  logic        phys_vld_i = 1'b0, pool_vld_i = 1'b0, os_vld_i = 1'b0, usr_vld_i = 1'b0;
  logic [27:0] pool_cam_i = '0, os_cam_i = '0;
  logic [7:0]  usr_lsn_i = '0;
  logic [27:0] hw_cam_o;
  logic        hit_vld_o;
  logic [2:0]  hit_ring_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  ctxm_ring_match u0 (.*);

  typedef struct packed {
    logic        fmt;
    logic        ign;
    logic [27:0] tgt;
    logic [3:0]  vm;       // {phys, pool, os, usr}
    logic [27:0] pool_cam;
    logic [27:0] os_cam;
    logic [7:0]  ctx_lsn;
    logic [7:0]  req_lsn;
    logic        wide;
    logic [2:0]  exp;
    logic [7:0]  req;      // requirement number for messages
  } vec_t;

  localparam logic [27:0] PC = 28'h1234567;
  localparam logic [27:0] OC = 28'h200ABCD;
  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 28'h30000A5, 4'hF, PC, OC, 8'd5, 8'd5, 1'b0, 3'd4, 8'd4},
    '{1'b0, 1'b0, 28'h30000A5, 4'hF, PC, OC, 8'd5, 8'd5, 1'b1, 3'd0, 8'd8},
    '{1'b0, 1'b0, 28'h30001A5, 4'hF, PC, OC, 8'd5, 8'd5, 1'b1, 3'd4, 8'd8},
    '{1'b0, 1'b0, 28'h30000A5, 4'h7, PC, OC, 8'd5, 8'd5, 1'b0, 3'd0, 8'd4},
    '{1'b0, 1'b0, PC,          4'hF, PC, OC, 8'd5, 8'd5, 1'b0, 3'd3, 8'd5},
    '{1'b0, 1'b0, PC,          4'hB, PC, OC, 8'd5, 8'd5, 1'b0, 3'd0, 8'd5},
    '{1'b0, 1'b0, OC,          4'hF, PC, OC, 8'd5, 8'd5, 1'b0, 3'd2, 8'd6},
    '{1'b0, 1'b0, OC,          4'hD, PC, OC, 8'd5, 8'd5, 1'b0, 3'd0, 8'd6},
    '{1'b0, 1'b1, 28'h30000A5, 4'hF, PC, OC, 8'd5, 8'd5, 1'b0, 3'd0, 8'd3},
    '{1'b1, 1'b0, OC,          4'hF, PC, OC, 8'd5, 8'd5, 1'b0, 3'd1, 8'd7},
    '{1'b1, 1'b0, OC,          4'hF, PC, OC, 8'd5, 8'd6, 1'b0, 3'd0, 8'd7},
    '{1'b1, 1'b0, OC,          4'hE, PC, OC, 8'd5, 8'd5, 1'b0, 3'd0, 8'd7},
    '{1'b1, 1'b0, OC,          4'hD, PC, OC, 8'd5, 8'd5, 1'b0, 3'd0, 8'd7},
    '{1'b1, 1'b0, 28'h30000A5, 4'hF, PC, OC, 8'd5, 8'd5, 1'b0, 3'd0, 8'd7},
    '{1'b0, 1'b0, 28'h30000A5, 4'hF, 28'h30000A5, 28'h30000A5, 8'd5, 8'd5, 1'b0, 3'd4, 8'd4},
    '{1'b0, 1'b0, 28'h0234567, 4'hF, PC, OC, 8'd5, 8'd5, 1'b0, 3'd0, 8'd10},
    '{1'b1, 1'b1, OC,          4'hF, PC, OC, 8'd5, 8'd5, 1'b0, 3'd1, 8'd7}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    req_fmt_i  = v.fmt;  req_ign_i = v.ign;
    {req_blk_i, req_idx_i} = v.tgt;
    {phys_vld_i, pool_vld_i, os_vld_i, usr_vld_i} = v.vm;
    pool_cam_i = v.pool_cam; os_cam_i = v.os_cam;
    usr_lsn_i  = v.ctx_lsn;  req_lsn_i = v.req_lsn;
    tid_wide_i = v.wide;
  endtask

  initial begin : watchdog
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R9 reset state
    #12;
    check("R9 vld", 32'(hit_vld_o), 0);
    check("R9 ring", 32'(hit_ring_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;

    // R8 identity line, both widths
    tid_wide_i = 1'b0; #1;
    check("R8 narrow", 32'(hw_cam_o), 32'h30000A5);
    tid_wide_i = 1'b1; #1;
    check("R8 wide", 32'(hw_cam_o), 32'h30001A5);
    pid_i = 16'hFFFF; #1;
    check("R8 wide masked", 32'(hw_cam_o), 32'h30001FF);
    tid_wide_i = 1'b0; #1;
    check("R8 narrow masked", 32'(hw_cam_o), 32'h30000FF);
    pid_i = 16'h01A5;

    // table walk (R2..R7, R10)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      apply(VECS[i]);
      req_valid_i = 1'b1;
      @(negedge clk_i);
      req_valid_i = 1'b0;
      check($sformatf("R%0d vec%0d", VECS[i].req, i), 32'(hit_ring_o), 32'(VECS[i].exp));
      check($sformatf("R1 vld vec%0d", i), 32'(hit_vld_o), 1);
    end

    // R1 no request: output idles even with matching context present
    @(negedge clk_i);
    check("R1 idle vld", 32'(hit_vld_o), 0);
    check("R1 idle ring", 32'(hit_ring_o), 0);

    // R5 priority: pool beats OS when both match and phys is off
    apply(VECS[14]);
    phys_vld_i = 1'b0;
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check("R5 pool over os", 32'(hit_ring_o), 3);

    // R4 back-to-back requests, second one switches width mid-stream
    apply(VECS[0]);
    req_valid_i = 1'b1;
    @(negedge clk_i);
    check("R4 b2b first", 32'(hit_ring_o), 4);
    tid_wide_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check("R4 b2b second", 32'(hit_ring_o), 0);

    // R9 asynchronous reset mid-run
    apply(VECS[0]);
    req_valid_i = 1'b1;
    @(negedge clk_i);
    rst_ni = 1'b0; #1;
    check("R9 async ring", 32'(hit_ring_o), 0);
    check("R9 async vld", 32'(hit_vld_o), 0);
    req_valid_i = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule